// File: doc/BRIEF.md
# Low-Power Mode Clock Controller

This block steps a processor subsystem into and out of five power-down levels. While active it keeps three derived clocks running: the core/bus clock, the peripheral clock and the analog clock. When software raises a sleep request with a non-zero mode code and no wake source is pending, the controller stores the mode. It then closes the clock gates that mode needs and tells the core to enter sleep or deep sleep.

A wake source starts the return. Modes 1 to 3 are the light modes: the interrupt or the DMA-complete line can end them, and they need a short wake delay of `LIGHT_WAKE_CYC` core-clock cycles (3 to 5 is typical). Modes 4 and 5 are the deep modes: only the interrupt ends them, and their delay is `DEEP_WAKE_CYC` cycles, long enough to cover a microsecond-scale settling time. When the delay has run out, the block opens all gates again, drops the sleep indicators and raises a single-cycle wake-done strobe.

The gate enables are re-timed on the falling edge of the clock. A downstream AND-type gate therefore never sees an enable change while the clock is high, so no pulse of a gated clock is ever cut short.

The state machine has five states:
- ST_ACTIVE: all clocks run.
- ST_HALT: a light mode is held.
- ST_DEEP: a deep mode is held.
- ST_WAKE_LIGHT: the light wake delay is counting.
- ST_WAKE_DEEP: the deep wake delay is counting.

It has six transitions:
- ACTIVE→HALT: a request with mode 1–3 and no wake source.
- ACTIVE→DEEP: a request with mode 4–5 and no wake source.
- HALT→WAKE_LIGHT: the interrupt or the DMA-complete line.
- DEEP→WAKE_DEEP: the interrupt only.
- WAKE_LIGHT→ACTIVE: the light timer has expired.
- WAKE_DEEP→ACTIVE: the deep timer has expired.

Top module: `lpm_clk_ctrl`

## Requirements
- R1: After reset, all three gate enables are 1 and core_sleep_o, core_deep_o and wake_done_o are 0.
- R2: A sleep request is acted on only in the active state, only with a mode code of 1 to 5, and only when neither wake input is high in that cycle. A request with code 0, 6 or 7, or with a wake input high, leaves every output at its active value.
- R3: In mode 1, the core/bus enable is 0, the peripheral and analog enables are 1, core_sleep_o is 1 and core_deep_o is 0.
- R4: In mode 2, the peripheral enable is 0, the core/bus and analog enables are 1, core_sleep_o is 1 and core_deep_o is 0.
- R5: In mode 3, all three enables are 0, core_sleep_o is 1 and core_deep_o is 0.
- R6: In modes 4 and 5, all three enables are 0, core_deep_o is 1 and core_sleep_o is 0.
- R7: In a light mode, wake_irq_i or wake_dma_i sampled at clock edge k starts the wake. The sleep-state outputs hold through edge k+LIGHT_WAKE_CYC−1, and the block is active from edge k+LIGHT_WAKE_CYC.
- R8: In a deep mode, wake_dma_i has no effect. wake_irq_i sampled at edge k starts the wake. The deep-state outputs hold through edge k+DEEP_WAKE_CYC−1, and the block is active from edge k+DEEP_WAKE_CYC.
- R9: wake_done_o is 1 for exactly the first cycle after a wake completes.
- R10: The gate enables change only on the falling clock edge. In the high phase that follows a rising edge, the enables still show the values they had before that edge.
- R11: While the block is not active, changes on mode_i and sleep_req_i do not alter the gates or the sleep indicators.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock, source of all three gated clocks |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_i | input | 3 | Requested power-down level (0 = active, 1–5 = levels) |
| sleep_req_i | input | 1 | Request to enter the level on mode_i |
| wake_irq_i | input | 1 | Interrupt wake source, accepted in all levels |
| wake_dma_i | input | 1 | DMA-complete wake source, accepted in levels 1–3 |
| hclk_en_o | output | 1 | Core/bus clock gate enable |
| pclk_en_o | output | 1 | Peripheral clock gate enable |
| aclk_en_o | output | 1 | Analog clock gate enable |
| core_sleep_o | output | 1 | Core sleep indication |
| core_deep_o | output | 1 | Core deep-sleep indication |
| wake_done_o | output | 1 | One-cycle strobe when clocks are restored |

## Verification
The state register updates on the rising edge, and the gate enables follow at the next falling edge. The bench therefore drives inputs and samples every output 15 ns after a rising edge, once both have settled, and it checks the R10 hold separately 5 ns after the edge. Entry results are due one edge after the request. Wake results are due LIGHT_WAKE_CYC or DEEP_WAKE_CYC edges after the wake input is sampled: the bench checks the sleep outputs one edge before that point, and the active outputs with the wake-done strobe at exactly that edge. Random episodes mix mode codes, pending wake sources, hold lengths, ignored inputs during sleep and the choice of wake source, and expected values come from bench functions of the mode.

// File: rtl/lpm_pkg.sv
package lpm_pkg;

    typedef logic [2:0] lpm_mode_t;

    typedef enum logic [2:0] {
        ST_ACTIVE,
        ST_HALT,
        ST_DEEP,
        ST_WAKE_LIGHT,
        ST_WAKE_DEEP
    } lpm_state_t;

    // gate vector order: {core/bus, peripheral, analog}
    localparam int NUM_GATES = 3;

    typedef struct packed {
        logic hclk;
        logic pclk;
        logic aclk;
    } lpm_gate_t;

    localparam lpm_gate_t GATES_ALL_ON  = '{hclk: 1'b1, pclk: 1'b1, aclk: 1'b1};
    localparam lpm_gate_t GATES_ALL_OFF = '{hclk: 1'b0, pclk: 1'b0, aclk: 1'b0};

    function automatic logic mode_is_light(input lpm_mode_t m);
        return (m == 3'd1) || (m == 3'd2) || (m == 3'd3);
    endfunction

    function automatic logic mode_is_deep(input lpm_mode_t m);
        return (m == 3'd4) || (m == 3'd5);
    endfunction

    function automatic lpm_gate_t light_gates(input lpm_mode_t m);
        lpm_gate_t g;
        case (m)
            3'd1:    g = '{hclk: 1'b0, pclk: 1'b1, aclk: 1'b1};
            3'd2:    g = '{hclk: 1'b1, pclk: 1'b0, aclk: 1'b1};
            default: g = GATES_ALL_OFF;
        endcase
        return g;
    endfunction

endpackage

// File: rtl/lpm_wake_timer.sv
module lpm_wake_timer #(
    parameter int LIGHT_CYC = 4,
    parameter int DEEP_CYC  = 1540
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load_light_i,
    input  logic load_deep_i,
    output logic zero_o
);
    localparam int MAX_CYC = (DEEP_CYC > LIGHT_CYC) ? DEEP_CYC : LIGHT_CYC;
    localparam int CNT_W   = $clog2(MAX_CYC + 1);
    localparam logic [CNT_W-1:0] LIGHT_LOAD = CNT_W'(LIGHT_CYC - 1);
    localparam logic [CNT_W-1:0] DEEP_LOAD  = CNT_W'(DEEP_CYC - 1);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load_deep_i) begin
            cnt_q <= DEEP_LOAD;
        end else if (load_light_i) begin
            cnt_q <= LIGHT_LOAD;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign zero_o = (cnt_q == '0);

    AST_TIMER_HOLDS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (zero_o && !load_light_i && !load_deep_i) |=> zero_o); // R7

    AST_LOAD_LEAVES_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (load_deep_i && DEEP_CYC > 1) |=> !zero_o); // R8

endmodule

// File: rtl/lpm_fsm.sv
module lpm_fsm
    import lpm_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  lpm_mode_t mode_i,
    input  logic      sleep_req_i,
    input  logic      wake_irq_i,
    input  logic      wake_dma_i,
    input  logic      timer_zero_i,
    output logic      load_light_o,
    output logic      load_deep_o,
    output lpm_gate_t gate_req_o,
    output logic      core_sleep_o,
    output logic      core_deep_o,
    output logic      wake_done_o
);
    lpm_state_t state_q, state_d;
    lpm_mode_t  mode_q;
    logic       done_q;
    logic       any_wake;

    assign any_wake = wake_irq_i | wake_dma_i;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_ACTIVE: begin
                if (sleep_req_i && !any_wake) begin
                    if (mode_is_light(mode_i))     state_d = ST_HALT;
                    else if (mode_is_deep(mode_i)) state_d = ST_DEEP;
                end
            end
            ST_HALT:       if (any_wake)     state_d = ST_WAKE_LIGHT;
            ST_DEEP:       if (wake_irq_i)   state_d = ST_WAKE_DEEP;
            ST_WAKE_LIGHT: if (timer_zero_i) state_d = ST_ACTIVE;
            ST_WAKE_DEEP:  if (timer_zero_i) state_d = ST_ACTIVE;
            default:                         state_d = ST_ACTIVE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_ACTIVE;
            mode_q  <= '0;
            done_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_ACTIVE && state_d != ST_ACTIVE) mode_q <= mode_i;
            done_q  <= (state_q != ST_ACTIVE) && (state_d == ST_ACTIVE);
        end
    end

    always_comb begin
        load_light_o = 1'b0;
        load_deep_o  = 1'b0;
        gate_req_o   = GATES_ALL_ON;
        core_sleep_o = 1'b0;
        core_deep_o  = 1'b0;
        unique case (state_q)
            ST_ACTIVE: ;
            ST_HALT: begin
                gate_req_o   = light_gates(mode_q);
                core_sleep_o = 1'b1;
                load_light_o = (state_d == ST_WAKE_LIGHT);
            end
            ST_WAKE_LIGHT: begin
                gate_req_o   = light_gates(mode_q);
                core_sleep_o = 1'b1;
            end
            ST_DEEP: begin
                gate_req_o   = GATES_ALL_OFF;
                core_deep_o  = 1'b1;
                load_deep_o  = (state_d == ST_WAKE_DEEP);
            end
            ST_WAKE_DEEP: begin
                gate_req_o   = GATES_ALL_OFF;
                core_deep_o  = 1'b1;
            end
            default: ;
        endcase
    end

    assign wake_done_o = done_q;

    AST_DMA_NO_DEEP_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DEEP && !wake_irq_i) |=> (state_q == ST_DEEP)); // R8

    AST_MODE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_ACTIVE) |=> $stable(mode_q)); // R11

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        wake_done_o |=> !wake_done_o); // R9

    AST_DONE_IN_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
        wake_done_o |-> (state_q == ST_ACTIVE)); // R9

    AST_ENTRY_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ACTIVE && any_wake) |=> (state_q == ST_ACTIVE)); // R2

endmodule

// File: rtl/lpm_gate_retime.sv
module lpm_gate_retime #(
    parameter int NUM = 3
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NUM-1:0] req_i,
    output logic [NUM-1:0] en_o
);
    for (genvar g = 0; g < NUM; g++) begin : g_gate
        always_ff @(negedge clk or negedge rst_n) begin
            if (!rst_n) en_o[g] <= 1'b1;
            else        en_o[g] <= req_i[g];
        end
    end

endmodule

// File: rtl/lpm_clk_ctrl.sv
module lpm_clk_ctrl
    import lpm_pkg::*;
#(
    parameter int LIGHT_WAKE_CYC = 4,
    parameter int DEEP_WAKE_CYC  = 1540
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] mode_i,
    input  logic       sleep_req_i,
    input  logic       wake_irq_i,
    input  logic       wake_dma_i,
    output logic       hclk_en_o,
    output logic       pclk_en_o,
    output logic       aclk_en_o,
    output logic       core_sleep_o,
    output logic       core_deep_o,
    output logic       wake_done_o
);
    logic                 load_light, load_deep, timer_zero;
    lpm_gate_t            gate_req;
    logic [NUM_GATES-1:0] gate_en;

    lpm_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .mode_i       (mode_i),
        .sleep_req_i  (sleep_req_i),
        .wake_irq_i   (wake_irq_i),
        .wake_dma_i   (wake_dma_i),
        .timer_zero_i (timer_zero),
        .load_light_o (load_light),
        .load_deep_o  (load_deep),
        .gate_req_o   (gate_req),
        .core_sleep_o (core_sleep_o),
        .core_deep_o  (core_deep_o),
        .wake_done_o  (wake_done_o)
    );

    lpm_wake_timer #(
        .LIGHT_CYC (LIGHT_WAKE_CYC),
        .DEEP_CYC  (DEEP_WAKE_CYC)
    ) u_timer (
        .clk          (clk),
        .rst_n        (rst_n),
        .load_light_i (load_light),
        .load_deep_i  (load_deep),
        .zero_o       (timer_zero)
    );

    lpm_gate_retime #(
        .NUM (NUM_GATES)
    ) u_retime (
        .clk   (clk),
        .rst_n (rst_n),
        .req_i (gate_req),
        .en_o  (gate_en)
    );

    assign hclk_en_o = gate_en[2];
    assign pclk_en_o = gate_en[1];
    assign aclk_en_o = gate_en[0];

    AST_DEEP_CLOCKS_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (core_deep_o && $past(core_deep_o)) |-> !(hclk_en_o || pclk_en_o || aclk_en_o)); // R6

    AST_SLEEP_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(core_sleep_o && core_deep_o)); // R6

    AST_DONE_CLOCKS_ON: assert property (@(posedge clk) disable iff (!rst_n)
        wake_done_o |=> (hclk_en_o && pclk_en_o && aclk_en_o)); // R9

endmodule

// File: tb/lpm_clk_ctrl_test.sv
module lpm_clk_ctrl_test;
    localparam int LW = 4;
    localparam int DW = 1540;

    logic       clk = 1'b0;
    logic       rst_n;
    logic [2:0] mode_i;
    logic       sleep_req_i, wake_irq_i, wake_dma_i;
    logic       hclk_en_o, pclk_en_o, aclk_en_o;
    logic       core_sleep_o, core_deep_o, wake_done_o;

    int n_chk  = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    lpm_clk_ctrl #(.LIGHT_WAKE_CYC(LW), .DEEP_WAKE_CYC(DW)) uut (
        .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .sleep_req_i(sleep_req_i),
        .wake_irq_i(wake_irq_i), .wake_dma_i(wake_dma_i),
        .hclk_en_o(hclk_en_o), .pclk_en_o(pclk_en_o), .aclk_en_o(aclk_en_o),
        .core_sleep_o(core_sleep_o), .core_deep_o(core_deep_o), .wake_done_o(wake_done_o)
    );

    function automatic logic [2:0] exp_gates(input logic [2:0] m);
        case (m)
            3'd1:                   return 3'b011;
            3'd2:                   return 3'b101;
            3'd3, 3'd4, 3'd5:       return 3'b000;
            default:                return 3'b111;
        endcase
    endfunction

    function automatic logic is_lt(input logic [2:0] m);
        return m >= 3'd1 && m <= 3'd3;
    endfunction

    function automatic logic is_dp(input logic [2:0] m);
        return m == 3'd4 || m == 3'd5;
    endfunction

    function automatic string mode_tag(input logic [2:0] m);
        case (m)
            3'd1:    return "R3";
            3'd2:    return "R4";
            3'd3:    return "R5";
            default: return "R6";
        endcase
    endfunction

    function automatic logic [2:0] en_now();
        return {hclk_en_o, pclk_en_o, aclk_en_o};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #15;
    endtask

    task automatic tick_mid(output logic [2:0] mid);
        @(posedge clk);
        #5;
        mid = en_now();
        #10;
    endtask

    task automatic expect_active(input string req);
        chk(req, {27'd0, en_now(), core_sleep_o, core_deep_o}, {27'd0, 3'b111, 2'b00});
    endtask

    task automatic expect_asleep(input string req, input logic [2:0] m);
        chk(req, {27'd0, en_now(), core_sleep_o, core_deep_o},
            {27'd0, exp_gates(m), is_lt(m), is_dp(m)});
    endtask

    task automatic episode(input logic [2:0] m, input bit pend, input bit use_dma, input int hold);
        logic [2:0] mid;
        int         wait_n;
        mode_i      = m;
        sleep_req_i = 1'b1;
        wake_irq_i  = pend && !use_dma;
        wake_dma_i  = pend && use_dma;
        tick_mid(mid);
        sleep_req_i = 1'b0;
        wake_irq_i  = 1'b0;
        wake_dma_i  = 1'b0;
        if (pend || !(is_lt(m) || is_dp(m))) begin
            expect_active("R2 request ignored");
            tick();
            expect_active("R2 still active after ignored request");
            return;
        end
        chk("R10 enables held in high phase on entry", {29'd0, mid}, {29'd0, 3'b111});
        expect_asleep({mode_tag(m), " sleep outputs"}, m);
        for (int i = 0; i < hold; i++) begin
            mode_i      = 3'($urandom);
            sleep_req_i = 1'($urandom);
            wake_dma_i  = is_dp(m);
            tick();
            expect_asleep(is_dp(m) ? "R8 dma ignored in deep / R11" : "R11 inputs ignored asleep", m);
        end
        sleep_req_i = 1'b0;
        wake_dma_i  = 1'b0;
        if (is_dp(m) || !use_dma) wake_irq_i = 1'b1;
        else                      wake_dma_i = 1'b1;
        tick();
        wake_irq_i = 1'b0;
        wake_dma_i = 1'b0;
        wait_n = is_dp(m) ? DW : LW;
        for (int i = 0; i < wait_n - 1; i++) tick();
        expect_asleep(is_dp(m) ? "R8 asleep one edge before deep wake" : "R7 asleep one edge before light wake", m);
        tick_mid(mid);
        chk("R10 enables held in high phase on wake", {29'd0, mid}, {29'd0, exp_gates(m)});
        expect_active(is_dp(m) ? "R8 active after deep delay" : "R7 active after light delay");
        chk("R9 wake_done raised", {31'd0, wake_done_o}, 32'd1);
        tick();
        chk("R9 wake_done single cycle", {31'd0, wake_done_o}, 32'd0);
    endtask

    initial begin
        #(20 * 200000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        void'($urandom(32'd5117));
        rst_n       = 1'b0;
        mode_i      = '0;
        sleep_req_i = 1'b0;
        wake_irq_i  = 1'b0;
        wake_dma_i  = 1'b0;
        repeat (3) tick();
        expect_active("R1 outputs during reset");
        chk("R1 wake_done during reset", {31'd0, wake_done_o}, 32'd0);
        rst_n = 1'b1;
        tick();
        expect_active("R1 outputs after reset");
        chk("R1 wake_done after reset", {31'd0, wake_done_o}, 32'd0);

        for (int m = 1; m <= 5; m++) begin
            episode(3'(m), 1'b0, 1'b0, 2);
            episode(3'(m), 1'b0, 1'b1, 1);
        end
        episode(3'd0, 1'b0, 1'b0, 1);
        episode(3'd6, 1'b0, 1'b0, 1);
        episode(3'd7, 1'b0, 1'b0, 1);
        episode(3'd1, 1'b1, 1'b0, 1);
        episode(3'd4, 1'b1, 1'b1, 1);

        for (int i = 0; i < 40; i++) begin
            episode(3'($urandom % 8), ($urandom % 4) == 0, 1'($urandom), 1 + ($urandom % 4));
        end

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule